// File: doc/BRIEF.md
# Page-mode DRAM controller

This block turns a simple valid/ready request port into strobe sequences for an asynchronous DRAM device. The device has one set of shared address pins and four active-low strobes: row strobe, column strobe, write enable and output enable. Each request address is split into a row part (upper bits) and a column part (lower bits). After an access the row stays open. A later request to the same row needs only a new column strobe. A request to another row first closes the open row, waits out the precharge time, and then activates the new row.

All device timing is given as parameters counted in controller clock cycles:
- row cycle time
- row-strobe-to-data time
- column-strobe-to-data time
- column cycle time
- precharge time

A refresh scheduler raises a request once per fixed interval. The refresh is a row-strobe-only cycle on the next row of a counter that walks all rows. It takes priority over new requests, and any open row is closed before it starts. The data pins are split into an output word, an output enable and an input word, so a pad ring can build the bidirectional bus.

Top module: `fpm_dram_ctrl`

## Requirements
- R1: During and right after reset, all four strobes are high, the data pins are not driven, `rsp_valid` is 0 and `req_ready` is 1.
- R2: The row is `req_addr[ROW_W+COL_W-1:COL_W]`. It is on `dram_addr` when the row strobe falls. The column is `req_addr[COL_W-1:0]`. It is on `dram_addr` when the column strobe falls.
- R3: The column strobe falls only while the row strobe is low. Every row access begins with a falling row strobe.
- R4: A read drives output enable low and write enable high. The two are never low together. Each read returns exactly one `rsp_valid` pulse carrying the data. A write returns none. A read accepted while idle responds 1+T_RAC cycles after acceptance, provided the row spacing is already met.
- R5: A write uses the early form. Write enable is low for at least one cycle before the column strobe falls. The data pins are driven while output enable stays high.
- R6: A request to the open row causes no row strobe activity. A read of the open row responds 1+T_CAC cycles after acceptance.
- R7: On a row change, the row strobe stays high for at least T_RP cycles. Successive row-strobe falls are at least T_RC cycles apart. A read that misses the open row responds T_RP+T_RAC cycles after acceptance, provided the row spacing is already met.
- R8: Successive column-strobe falls are at least T_PC cycles apart. Read data is taken only when the column strobe has been low for at least T_CAC cycles and the row strobe for at least T_RAC cycles.
- R9: Every REF_INTERVAL cycles a refresh is scheduled. It is a row-strobe-only cycle on the row counter, which starts at 0 and counts up modulo the number of rows. Refresh takes priority over requests: `req_ready` is low while it is pending, and an open row is closed first.
- R10: `req_ready` is high only when the controller is idle or holds an open row with no access in flight. While it is high, the column strobe, write enable and output enable are all high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Controller clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted on this edge when valid |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | ROW_W+COL_W | Row in upper bits, column in lower bits |
| req_wdata | input | DATA_W | Write data |
| rsp_valid | output | 1 | One-cycle pulse with read data |
| rsp_rdata | output | DATA_W | Read data |
| dram_ras_n | output | 1 | Row strobe, active low |
| dram_cas_n | output | 1 | Column strobe, active low |
| dram_we_n | output | 1 | Write enable, active low |
| dram_oe_n | output | 1 | Output enable, active low |
| dram_addr | output | max(ROW_W,COL_W) | Shared row/column address pins |
| dram_dq_o | output | DATA_W | Data toward the device |
| dram_dq_oe | output | 1 | 1 = controller drives the data pins |
| dram_dq_i | input | DATA_W | Data from the device |

## Verification
Read responses are due at fixed cycle distances from the acceptance edge:
- 1+T_RAC cycles from idle;
- 1+T_CAC cycles on an open-row hit;
- T_RP+T_RAC cycles on a row miss once the row spacing is met.

The driver records the acceptance cycle with each expected read in a queue. The monitor compares the cycle of each `rsp_valid` against it, using a stated latency only where the sequence guarantees that no refresh or spacing stall intervenes. A device model at the falling clock edge counts strobe-low cycles. It returns correct data only once both access times are met, so early sampling yields wrong data. It also measures every row, precharge and column spacing, and the order and interval of refresh rows.

// File: rtl/fpm_dram_pkg.sv
package fpm_dram_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,   // no row open
    ST_OPEN,   // row open, waiting for a request
    ST_PRE,    // row strobe high, waiting to activate
    ST_ROWA,   // row just activated, column goes onto the pins
    ST_CSET,   // column on pins, waiting for column spacing
    ST_CAS,    // column strobe low
    ST_REF     // refresh row strobe low
  } fpm_state_e;

  // An age counter restarted on an event edge holds k-1 at the edge k
  // cycles later; an edge is allowed when that distance reaches gap.
  function automatic logic gap_met(input int unsigned age, input int unsigned gap);
    return (age + 1) >= gap;
  endfunction

endpackage

// File: rtl/fpm_dram_age.sv
module fpm_dram_age #(
  parameter int LIMIT = 11,
  parameter int W     = $clog2(LIMIT + 1)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         restart,
  output logic [W-1:0] age
);
  // Saturating cycle counter; saturated out of reset so no spacing
  // constraint applies before the first event.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 age <= W'(LIMIT);
    else if (restart)           age <= '0;
    else if (age != W'(LIMIT))  age <= age + 1'b1;
  end
endmodule

// File: rtl/fpm_dram_refresh.sv
module fpm_dram_refresh #(
  parameter int ROW_W    = 6,
  parameter int INTERVAL = 780,
  parameter int TW       = $clog2(INTERVAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  output logic             due,
  output logic [ROW_W-1:0] row
);
  logic [TW-1:0] tmr;
  logic          tick;

  assign tick = (tmr == TW'(INTERVAL - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tmr <= '0;
      due <= 1'b0;
      row <= '0;
    end else begin
      tmr <= tick ? '0 : tmr + 1'b1;
      if (tick)       due <= 1'b1;
      else if (start) due <= 1'b0;
      if (start)      row <= row + 1'b1;
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl.sv
module fpm_dram_ctrl
  import fpm_dram_pkg::*;
#(
  parameter int ROW_W        = 6,
  parameter int COL_W        = 5,
  parameter int DATA_W       = 8,
  parameter int T_RC         = 11,
  parameter int T_RAC        = 6,
  parameter int T_CAC        = 2,
  parameter int T_PC         = 4,
  parameter int T_RP         = 4,
  parameter int REF_INTERVAL = 780,
  parameter int ADDR_W       = ROW_W + COL_W,
  parameter int PIN_W        = (ROW_W > COL_W) ? ROW_W : COL_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              dram_ras_n,
  output logic              dram_cas_n,
  output logic              dram_we_n,
  output logic              dram_oe_n,
  output logic [PIN_W-1:0]  dram_addr,
  output logic [DATA_W-1:0] dram_dq_o,
  output logic              dram_dq_oe,
  input  logic [DATA_W-1:0] dram_dq_i
);
  localparam int T_RCD  = T_RAC - T_CAC;   // row fall to column fall
  localparam int T_RAS  = T_RC - T_RP;     // refresh row-low time
  localparam int CNT_W  = $clog2(T_RC + 1);
  localparam int RAGE_W = $clog2(T_RC + 1);
  localparam int CAGE_W = $clog2(T_PC + 1);
  localparam int PAGE_W = $clog2(T_RP + 1);

  fpm_state_e        state;
  logic [ROW_W-1:0]  open_row, pend_row;
  logic [COL_W-1:0]  pend_col;
  logic              pend_write, pend_ref;
  logic [DATA_W-1:0] pend_wdata;
  logic [CNT_W-1:0]  cnt;

  logic [ROW_W-1:0]  req_row;
  logic [COL_W-1:0]  req_col;
  logic              row_hit;

  // named internal events
  logic              ras_fall_ev, ras_rise_ev, cas_fall_ev, ref_start_ev;
  logic              fire_row, fire_col, col_done, ref_done;

  logic [RAGE_W-1:0] ras_age;
  logic [CAGE_W-1:0] cas_age;
  logic [PAGE_W-1:0] pre_age;
  logic              ref_due;
  logic [ROW_W-1:0]  ref_row;

  assign req_row = req_addr[ADDR_W-1:COL_W];
  assign req_col = req_addr[COL_W-1:0];
  assign row_hit = (req_row == open_row);

  assign req_ready = ((state == ST_IDLE) || (state == ST_OPEN)) && !ref_due;

  assign fire_row = (state == ST_PRE)
                    && gap_met(int'(ras_age), T_RC) && gap_met(int'(pre_age), T_RP);
  assign fire_col = (state == ST_CSET)
                    && gap_met(int'(ras_age), T_RCD) && gap_met(int'(cas_age), T_PC);
  assign col_done = (state == ST_CAS) && (cnt == '0);
  assign ref_done = (state == ST_REF) && (cnt == '0);

  assign ras_fall_ev  = fire_row;
  assign cas_fall_ev  = fire_col;
  assign ref_start_ev = fire_row && pend_ref;
  assign ras_rise_ev  = ((state == ST_OPEN) && (ref_due || (req_valid && !row_hit)))
                        || ref_done;

  fpm_dram_age #(.LIMIT(T_RC)) u_ras_age (
    .clk(clk), .rst_n(rst_n), .restart(ras_fall_ev), .age(ras_age));
  fpm_dram_age #(.LIMIT(T_PC)) u_cas_age (
    .clk(clk), .rst_n(rst_n), .restart(cas_fall_ev), .age(cas_age));
  fpm_dram_age #(.LIMIT(T_RP)) u_pre_age (
    .clk(clk), .rst_n(rst_n), .restart(ras_rise_ev), .age(pre_age));

  fpm_dram_refresh #(.ROW_W(ROW_W), .INTERVAL(REF_INTERVAL)) u_refresh (
    .clk(clk), .rst_n(rst_n), .start(ref_start_ev), .due(ref_due), .row(ref_row));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state      <= ST_IDLE;
      open_row   <= '0;
      pend_row   <= '0;
      pend_col   <= '0;
      pend_write <= 1'b0;
      pend_ref   <= 1'b0;
      pend_wdata <= '0;
      cnt        <= '0;
      dram_ras_n <= 1'b1;
      dram_cas_n <= 1'b1;
      dram_we_n  <= 1'b1;
      dram_oe_n  <= 1'b1;
      dram_addr  <= '0;
      dram_dq_o  <= '0;
      dram_dq_oe <= 1'b0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
    end else begin
      rsp_valid <= 1'b0;
      case (state)
        ST_IDLE: begin
          if (ref_due) begin
            pend_ref <= 1'b1;
            state    <= ST_PRE;
          end else if (req_valid) begin
            pend_ref   <= 1'b0;
            pend_row   <= req_row;
            pend_col   <= req_col;
            pend_write <= req_write;
            pend_wdata <= req_wdata;
            state      <= ST_PRE;
          end
        end
        ST_OPEN: begin
          if (ref_due) begin
            pend_ref   <= 1'b1;
            dram_ras_n <= 1'b1;
            state      <= ST_PRE;
          end else if (req_valid) begin
            pend_ref   <= 1'b0;
            pend_row   <= req_row;
            pend_col   <= req_col;
            pend_write <= req_write;
            pend_wdata <= req_wdata;
            if (row_hit) begin
              dram_addr  <= PIN_W'(req_col);
              dram_we_n  <= ~req_write;
              dram_dq_oe <= req_write;
              dram_dq_o  <= req_wdata;
              state      <= ST_CSET;
            end else begin
              dram_ras_n <= 1'b1;
              state      <= ST_PRE;
            end
          end
        end
        ST_PRE: begin
          if (fire_row) begin
            dram_ras_n <= 1'b0;
            if (pend_ref) begin
              dram_addr <= PIN_W'(ref_row);
              cnt       <= CNT_W'(T_RAS - 1);
              state     <= ST_REF;
            end else begin
              dram_addr  <= PIN_W'(pend_row);
              open_row   <= pend_row;
              dram_we_n  <= ~pend_write;
              dram_dq_oe <= pend_write;
              dram_dq_o  <= pend_wdata;
              state      <= ST_ROWA;
            end
          end
        end
        ST_ROWA: begin
          dram_addr <= PIN_W'(pend_col);
          state     <= ST_CSET;
        end
        ST_CSET: begin
          if (fire_col) begin
            dram_cas_n <= 1'b0;
            dram_oe_n  <= pend_write;
            cnt        <= CNT_W'(T_CAC - 1);
            state      <= ST_CAS;
          end
        end
        ST_CAS: begin
          if (col_done) begin
            dram_cas_n <= 1'b1;
            dram_oe_n  <= 1'b1;
            dram_we_n  <= 1'b1;
            dram_dq_oe <= 1'b0;
            rsp_valid  <= ~pend_write;
            if (!pend_write) rsp_rdata <= dram_dq_i;
            state      <= ST_OPEN;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        ST_REF: begin
          if (ref_done) begin
            dram_ras_n <= 1'b1;
            state      <= ST_IDLE;
          end else begin
            cnt <= cnt - 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/fpm_dram_ctrl_chk.sv
module fpm_dram_ctrl_chk #(
  parameter int T_RC = 11,
  parameter int T_PC = 4,
  parameter int T_RP = 4
) (
  input logic clk,
  input logic rst_n,
  input logic ras_n,
  input logic cas_n,
  input logic we_n,
  input logic oe_n,
  input logic dq_oe,
  input logic req_ready,
  input logic rsp_valid
);
  logic        ras_q, cas_q;
  logic [15:0] ras_gap, cas_gap, hi_gap;
  logic        ras_fell, ras_rose, cas_fell;

  assign ras_fell = ras_q && !ras_n;
  assign ras_rose = !ras_q && ras_n;
  assign cas_fell = cas_q && !cas_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ras_q   <= 1'b1;
      cas_q   <= 1'b1;
      ras_gap <= 16'hffff;
      cas_gap <= 16'hffff;
      hi_gap  <= 16'hffff;
    end else begin
      ras_q <= ras_n;
      cas_q <= cas_n;
      if (ras_fell)                 ras_gap <= '0;
      else if (ras_gap != 16'hffff) ras_gap <= ras_gap + 1'b1;
      if (cas_fell)                 cas_gap <= '0;
      else if (cas_gap != 16'hffff) cas_gap <= cas_gap + 1'b1;
      if (ras_rose)                 hi_gap  <= '0;
      else if (hi_gap != 16'hffff)  hi_gap  <= hi_gap + 1'b1;
    end
  end

  assert_we_oe_excl_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !(!we_n && !oe_n));
  assert_rsp_after_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> !$past(oe_n));
  assert_cas_in_row_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fell |-> !ras_n);
  assert_early_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (cas_fell && !we_n) |-> !$past(we_n));
  assert_dq_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
    dq_oe |-> (oe_n && !we_n));
  assert_row_cycle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fell |-> (ras_gap >= 16'(T_RC - 1)));
  assert_precharge_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ras_fell |-> (hi_gap >= 16'(T_RP - 1)));
  assert_col_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    cas_fell |-> (cas_gap >= 16'(T_PC - 1)));
  assert_ready_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready |-> (cas_n && we_n && oe_n && !dq_oe));
endmodule

bind fpm_dram_ctrl fpm_dram_ctrl_chk #(.T_RC(T_RC), .T_PC(T_PC), .T_RP(T_RP)) u_chk (
  .clk(clk), .rst_n(rst_n), .ras_n(dram_ras_n), .cas_n(dram_cas_n),
  .we_n(dram_we_n), .oe_n(dram_oe_n), .dq_oe(dram_dq_oe),
  .req_ready(req_ready), .rsp_valid(rsp_valid));

// File: tb/fpm_dram_ctrl_tb.sv
module fpm_dram_ctrl_tb;
  localparam int ROW_W = 6, COL_W = 5, DATA_W = 8;
  localparam int T_RC = 11, T_RAC = 6, T_CAC = 2, T_PC = 4, T_RP = 4;
  localparam int REF_INT = 300;
  localparam int ADDR_W = ROW_W + COL_W, PIN_W = 6;
  localparam int NROWS = 1 << ROW_W, NCOLS = 1 << COL_W;
  localparam int REF_SLACK = 2 * T_RC + T_RAC + 6;

  logic clk = 1'b0, rst_n = 1'b0;
  always #5 clk = ~clk;

  logic req_valid = 0, req_write = 0, req_ready;
  logic [ADDR_W-1:0] req_addr = '0;
  logic [DATA_W-1:0] req_wdata = '0, rsp_rdata, dram_dq_o;
  logic [DATA_W-1:0] dram_dq_i = '0;
  logic rsp_valid, dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n, dram_dq_oe;
  logic [PIN_W-1:0] dram_addr;

  fpm_dram_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RC(T_RC),
    .T_RAC(T_RAC), .T_CAC(T_CAC), .T_PC(T_PC), .T_RP(T_RP),
    .REF_INTERVAL(REF_INT)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .dram_ras_n(dram_ras_n),
    .dram_cas_n(dram_cas_n), .dram_we_n(dram_we_n), .dram_oe_n(dram_oe_n),
    .dram_addr(dram_addr), .dram_dq_o(dram_dq_o), .dram_dq_oe(dram_dq_oe),
    .dram_dq_i(dram_dq_i));

  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;

  int checks = 0, bad = 0;
  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    checks++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic logic [7:0] init_pat(input int a);
    return 8'(a * 7 + 8'h3c);
  endfunction

  // ---------------- behavioural device model ----------------
  logic [7:0] mem [int];
  logic [7:0] exp_mem [int];
  logic pr_ras = 1, pr_cas = 1, pr_we = 1;
  int ras_lo = 0, cas_lo = 0, m_row = 0, m_col = 0;
  bit saw_cas = 0;
  int last_ras_fall = -1000, last_ras_rise = -1000, last_cas_fall = -1000;
  int last_ref = -1, exp_ref_row = 0, ref_count = 0, ras_falls = 0;
  int cur_row = 0, cur_col = 0;

  function automatic logic [7:0] stored(input int a);
    if (mem.exists(a)) return mem[a];
    return init_pat(a);
  endfunction

  always @(negedge clk) begin
    if (rst_n) begin
      if (!dram_we_n && !dram_oe_n) check(0, "R4", "we and oe low together", 0, 1);
      if (pr_ras && !dram_ras_n) begin
        ras_falls++;
        check(cyc - last_ras_fall >= T_RC, "R7", "row cycle spacing", cyc - last_ras_fall, T_RC);
        check(cyc - last_ras_rise >= T_RP, "R7", "precharge time", cyc - last_ras_rise, T_RP);
        last_ras_fall = cyc;
        m_row = int'(dram_addr);
        saw_cas = 0;
      end
      if (!pr_ras && dram_ras_n) begin
        if (!saw_cas) begin
          check(m_row == exp_ref_row, "R9", "refresh row order", m_row, exp_ref_row);
          if (last_ref >= 0)
            check((last_ras_fall - last_ref <= REF_INT + REF_SLACK) &&
                  (last_ras_fall - last_ref >= REF_INT - REF_SLACK),
                  "R9", "refresh interval", last_ras_fall - last_ref, REF_INT);
          else
            check(last_ras_fall <= REF_INT + REF_SLACK, "R9", "first refresh",
                  last_ras_fall, REF_INT);
          exp_ref_row = (exp_ref_row + 1) % NROWS;
          last_ref = last_ras_fall;
          ref_count++;
        end
        last_ras_rise = cyc;
      end
      if (pr_cas && !dram_cas_n) begin
        check(!dram_ras_n, "R3", "column strobe without row", dram_ras_n, 0);
        check(cyc - last_cas_fall >= T_PC, "R8", "column spacing", cyc - last_cas_fall, T_PC);
        last_cas_fall = cyc;
        saw_cas = 1;
        m_col = int'(dram_addr);
        check(m_row == cur_row, "R2", "row on pins", m_row, cur_row);
        check(m_col == cur_col, "R2", "column on pins", m_col, cur_col);
        if (!dram_we_n) begin
          check(!pr_we, "R5", "write enable ahead of column strobe", pr_we, 0);
          check(dram_dq_oe && dram_oe_n, "R5", "data driven with oe high", dram_dq_oe, 1);
          mem[m_row * NCOLS + m_col] = dram_dq_o;
        end
      end
    end
    pr_ras = dram_ras_n;
    pr_cas = dram_cas_n;
    pr_we  = dram_we_n;
    ras_lo = dram_ras_n ? 0 : ras_lo + 1;
    cas_lo = dram_cas_n ? 0 : cas_lo + 1;
    // correct data only once both access times have elapsed (R8)
    if (!dram_cas_n && !dram_oe_n && ras_lo >= T_RAC && cas_lo >= T_CAC)
      dram_dq_i = stored(m_row * NCOLS + m_col);
    else
      dram_dq_i = ~stored(m_row * NCOLS + m_col);
  end

  // ---------------- scoreboard ----------------
  typedef struct {
    logic [7:0] data;
    int         acc;
    int         lat;
    string      tag;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    exp_t e;
    if (rst_n && rsp_valid) begin
      if (sb.size() == 0) check(0, "R4", "response without read", rsp_rdata, 0);
      else begin
        e = sb.pop_front();
        check(rsp_rdata == e.data, e.tag, "read data", rsp_rdata, e.data);
        if (e.lat >= 0)
          check(cyc - e.acc == e.lat, e.tag, "read latency", cyc - e.acc, e.lat);
      end
    end
  end

  task automatic do_req(input bit wr, input int row, input int col,
                        input logic [7:0] d, input int lat, input string tag);
    exp_t e;
    int a;
    a = row * NCOLS + col;
    @(negedge clk);
    req_valid = 1; req_write = wr; req_addr = ADDR_W'(a); req_wdata = d;
    while (!req_ready) @(negedge clk);
    cur_row = row; cur_col = col;
    if (wr) exp_mem[a] = d;
    else begin
      e.data = exp_mem.exists(a) ? exp_mem[a] : init_pat(a);
      e.acc = cyc + 1; e.lat = lat; e.tag = tag;
      sb.push_back(e);
    end
    @(negedge clk);
    req_valid = 0;
    check(!req_ready, "R10", "ready low during access", req_ready, 0);
  endtask

  task automatic drain();
    while (sb.size() != 0) @(negedge clk);
    repeat (T_CAC + 2) @(negedge clk);
  endtask

  // watchdog
  always @(posedge clk) begin
    if (cyc > 150000) begin
      checks++; bad++;
      $display("FAIL watchdog run hung actual=%0d expected=%0d", cyc, 150000);
      $display("  test done: total=%0d bad=%0d", checks, bad);
      $finish;
    end
  end

  initial begin
    int f0;
    int lf;
    repeat (3) @(negedge clk);
    check(dram_ras_n && dram_cas_n && dram_we_n && dram_oe_n, "R1", "strobes in reset",
          {dram_ras_n, dram_cas_n, dram_we_n, dram_oe_n}, 15);
    rst_n = 1;
    @(negedge clk);
    check(req_ready == 1, "R1", "ready after reset", req_ready, 1);
    check(!dram_dq_oe && !rsp_valid, "R1", "bus released after reset",
          {dram_dq_oe, rsp_valid}, 0);
    // R4: read from idle
    do_req(0, 3, 5, 8'h00, 1 + T_RAC, "R4");
    drain();
    // R6: write and read in the open row, no row strobe activity
    f0 = ras_falls;
    do_req(1, 3, 9, 8'ha5, -1, "R5");
    do_req(0, 3, 9, 8'h00, 1 + T_CAC, "R6");
    do_req(0, 3, 5, 8'h00, 1 + T_CAC, "R6");
    drain();
    check(ras_falls == f0, "R6", "row strobe quiet on hits", ras_falls, f0);
    repeat (15) @(negedge clk);
    // R7: row miss after row spacing met
    do_req(0, 10, 2, 8'h00, T_RP + T_RAC, "R7");
    drain();
    do_req(1, 10, 2, 8'h11, -1, "R5");
    // R8: back-to-back hits paced by column spacing
    for (int c = 0; c < 4; c++) do_req(0, 10, c, 8'h00, 1 + T_CAC, "R8");
    // R7: immediate miss limited by row cycle time
    do_req(0, 20, 1, 8'h00, -1, "R7");
    do_req(0, 10, 2, 8'h00, -1, "R7");
    drain();
    // mixed traffic across refreshes (R2, R9)
    lf = 7;
    for (int i = 0; i < 400; i++) begin
      lf = (lf * 73 + 19) % 1021;
      do_req((lf % 3) == 0, lf % 8, (lf / 8) % NCOLS, 8'(lf), -1, "R2");
    end
    drain();
    f0 = ref_count;
    repeat (3 * REF_INT) @(negedge clk);
    check(ref_count - f0 >= 2, "R9", "refresh while idle", ref_count - f0, 3);
    check(ref_count >= cyc / REF_INT - 1, "R9", "refresh count", ref_count, cyc / REF_INT);
    check(sb.size() == 0, "R4", "all reads answered", sb.size(), 0);
    $display("  test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end
endmodule